// File: doc/BRIEF.md
# Bit-Plane Pixel Word Assembler

An array of in-pixel converters digitises a whole quarter image at once. Each converter is shared by a 2×2 group of pixels. The array is then read out one bit position at a time, much as rows of a memory are read. Every input beat therefore holds the same bit weight for every converter. This block gathers the planes of one quarter into a local store. Once the quarter is complete, it turns the store back into whole pixel words and emits them one per handshake. Each word comes with the image coordinates it belongs to.

A quarter opens with a beat flagged as first, which carries the most significant plane. The quarter index, sampled from that beat, picks which pixel of every 2×2 group the pass filled. While the stored quarter is being emitted, the block refuses new beats. Opening a new quarter before the current one is complete raises an error flag that stays set, and the unfinished quarter is thrown away. The converter grid size and the word width are parameters. The defaults are an 8×4 grid of converters, giving a 16×8 image, with 8-bit pixels.

Top module: `bit_plane_assembler`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and err_flag is 0.
- R2: A beat is taken when in_valid and in_ready are both 1. A taken beat with in_first=1 opens a quarter and holds bit PIX_BITS-1 of every pixel. Each later taken beat holds the next lower bit. Bit i of in_bits belongs to converter i.
- R3: out_valid rises in the cycle after the PIX_BITS-th plane of a quarter is taken, and never before.
- R4: A quarter's words come out in converter order 0 to N-1. Converter i sits at grid row i / ADC_COLS and grid column i % ADC_COLS, so the output is in raster order.
- R5: Each word carries out_x = 2·column + quarter[0] and out_y = 2·row + quarter[1].
- R6: While out_valid is 1 and out_ready is 0, the word and its coordinates hold. Each cycle with both high moves the output to the next word.
- R7: in_ready is 0 from the first output cycle until the cycle after the last word's handshake. Beats offered while in_ready is 0 are not taken.
- R8: A first-flagged beat taken while a quarter is partly collected sets err_flag and drops the partial planes. That beat then starts a new quarter, with its own quarter index, as its MSB plane.
- R9: Once set, err_flag stays at 1 until reset.
- R10: A taken beat with in_first=0 while no quarter is open is ignored.
- R11: The quarter index is sampled only from the first-flagged beat. in_quarter on the later beats of the quarter has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A plane beat is offered |
| in_first | input | 1 | Beat is the MSB plane of a new quarter |
| in_quarter | input | 2 | Quarter index: bit 0 column parity, bit 1 row parity |
| in_bits | input | ADC_COLS·ADC_ROWS | One bit per converter for the current plane |
| in_ready | output | 1 | Block can take a beat |
| out_valid | output | 1 | A pixel word is presented |
| out_ready | input | 1 | Consumer takes the presented word |
| out_pixel | output | PIX_BITS | Rebuilt pixel value |
| out_x | output | log2(ADC_COLS)+1 | Pixel column in the image |
| out_y | output | log2(ADC_ROWS)+1 | Pixel row in the image |
| err_flag | output | 1 | Sticky incomplete-quarter error |

## Verification
A wrong plane counter shows up at the ports in one of two ways. Either out_valid rises a cycle early or late against the count of taken beats, or every word of the quarter carries its bits at the wrong weights. Both appear on the first output cycle. A bad read index or a bad quarter latch puts wrong coordinates on the very first word. A handshake fault shows within one stalled cycle, as a changed word or a skipped coordinate. The bench compares out_valid, in_ready, err_flag and, when valid, the word and both coordinates against a behavioural model on every clock. Any divergence in the internal state is therefore flagged in the cycle it becomes visible.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  // Sequencer phases.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,  // no quarter open
    ST_COLLECT = 2'd1,  // planes being gathered
    ST_DRAIN   = 2'd2   // words being emitted
  } bpa_state_e;
endpackage

// File: rtl/bpa_plane_store.sv
module bpa_plane_store #(
  parameter int NUM_ADC  = 32,
  parameter int PIX_BITS = 8,
  localparam int PW      = $clog2(PIX_BITS)
) (
  input  logic                               clk,
  input  logic                               wr_go,
  input  logic [PW-1:0]                      wr_plane,
  input  logic [NUM_ADC-1:0]                 wr_bits,
  output logic [PIX_BITS-1:0][NUM_ADC-1:0]   planes
);
  // Data path storage: one register row per bit weight, no reset needed
  // because a row is only read after it has been written in the same quarter.
  logic [PIX_BITS-1:0][NUM_ADC-1:0] plane_q;

  for (genvar p = 0; p < PIX_BITS; p++) begin : g_plane
    logic row_en;
    assign row_en = wr_go && (wr_plane == PW'(p));
    always_ff @(posedge clk) begin
      if (row_en) begin
        plane_q[p] <= wr_bits;
      end
    end
  end

  assign planes = plane_q;
endmodule

// File: rtl/bpa_seq_ctrl.sv
module bpa_seq_ctrl
  import bpa_pkg::*;
#(
  parameter int NUM_ADC  = 32,
  parameter int PIX_BITS = 8,
  localparam int PW      = $clog2(PIX_BITS),
  localparam int IDX_W   = $clog2(NUM_ADC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic [1:0]       in_quarter,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             wr_go,
  output logic [PW-1:0]    wr_plane,
  output logic [1:0]       quarter,
  output logic [IDX_W-1:0] rd_idx,
  output logic             err_flag
);
  localparam logic [PW-1:0]    TOP_PLANE = PW'(PIX_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_ADC - 1);

  bpa_state_e        state_q, state_d;
  logic [PW-1:0]     plane_q, plane_d;
  logic [1:0]        quart_q, quart_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              err_q, err_d;
  logic              take;

  assign in_ready  = (state_q != ST_DRAIN);
  assign out_valid = (state_q == ST_DRAIN);
  assign take      = in_valid && in_ready;

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    plane_d  = plane_q;
    quart_d  = quart_q;
    idx_d    = idx_q;
    err_d    = err_q;
    wr_go    = 1'b0;
    wr_plane = plane_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take && in_first) begin
          wr_go    = 1'b1;
          wr_plane = TOP_PLANE;
          quart_d  = in_quarter;
          plane_d  = TOP_PLANE - PW'(1);
          state_d  = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (take) begin
          if (in_first) begin
            // restart: discard what was gathered so far
            err_d    = 1'b1;
            wr_go    = 1'b1;
            wr_plane = TOP_PLANE;
            quart_d  = in_quarter;
            plane_d  = TOP_PLANE - PW'(1);
          end else begin
            wr_go    = 1'b1;
            wr_plane = plane_q;
            if (plane_q == '0) begin
              state_d = ST_DRAIN;
              idx_d   = '0;
            end else begin
              plane_d = plane_q - PW'(1);
            end
          end
        end
      end
      ST_DRAIN: begin
        if (out_ready) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      plane_q <= '0;
      quart_q <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      plane_q <= plane_d;
      quart_q <= quart_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign quarter  = quart_q;
  assign rd_idx   = idx_q;
  assign err_flag = err_q;
endmodule

// File: rtl/bpa_coord_map.sv
module bpa_coord_map #(
  parameter int ADC_COLS = 8,
  parameter int ADC_ROWS = 4,
  parameter int PIX_BITS = 8,
  localparam int NUM_ADC = ADC_COLS * ADC_ROWS,
  localparam int COL_W   = $clog2(ADC_COLS),
  localparam int ROW_W   = $clog2(ADC_ROWS),
  localparam int IDX_W   = COL_W + ROW_W
) (
  input  logic [PIX_BITS-1:0][NUM_ADC-1:0] planes,
  input  logic [IDX_W-1:0]                 rd_idx,
  input  logic [1:0]                       quarter,
  output logic [PIX_BITS-1:0]              pixel,
  output logic [COL_W:0]                   pix_x,
  output logic [ROW_W:0]                   pix_y
);
  // Transpose: gather one bit of the selected converter from every plane.
  for (genvar b = 0; b < PIX_BITS; b++) begin : g_bit
    assign pixel[b] = planes[b][rd_idx];
  end

  // Grid sizes are powers of two, so column and row are index slices.
  assign pix_x = {rd_idx[COL_W-1:0], quarter[0]};
  assign pix_y = {rd_idx[IDX_W-1:COL_W], quarter[1]};
endmodule

// File: rtl/bit_plane_assembler.sv
module bit_plane_assembler #(
  parameter int ADC_COLS = 8,   // power of two, at least 2
  parameter int ADC_ROWS = 4,   // power of two, at least 2
  parameter int PIX_BITS = 8    // at least 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic                           in_first,
  input  logic [1:0]                     in_quarter,
  input  logic [ADC_COLS*ADC_ROWS-1:0]   in_bits,
  output logic                           in_ready,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [PIX_BITS-1:0]            out_pixel,
  output logic [$clog2(ADC_COLS):0]      out_x,
  output logic [$clog2(ADC_ROWS):0]      out_y,
  output logic                           err_flag
);
  localparam int NUM_ADC = ADC_COLS * ADC_ROWS;
  localparam int PW      = $clog2(PIX_BITS);
  localparam int IDX_W   = $clog2(NUM_ADC);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic                             wr_go;
  logic [PW-1:0]                    wr_plane;
  logic [1:0]                       quarter;
  logic [IDX_W-1:0]                 rd_idx;
  logic [PIX_BITS-1:0][NUM_ADC-1:0] planes;

  bpa_seq_ctrl #(
    .NUM_ADC  (NUM_ADC),
    .PIX_BITS (PIX_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_quarter (in_quarter),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .wr_go      (wr_go),
    .wr_plane   (wr_plane),
    .quarter    (quarter),
    .rd_idx     (rd_idx),
    .err_flag   (err_flag)
  );

  bpa_plane_store #(
    .NUM_ADC  (NUM_ADC),
    .PIX_BITS (PIX_BITS)
  ) u_store (
    .clk      (clk),
    .wr_go    (wr_go),
    .wr_plane (wr_plane),
    .wr_bits  (in_bits),
    .planes   (planes)
  );

  bpa_coord_map #(
    .ADC_COLS (ADC_COLS),
    .ADC_ROWS (ADC_ROWS),
    .PIX_BITS (PIX_BITS)
  ) u_map (
    .planes  (planes),
    .rd_idx  (rd_idx),
    .quarter (quarter),
    .pixel   (out_pixel),
    .pix_x   (out_x),
    .pix_y   (out_y)
  );
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
  parameter int ADC_COLS = 8,
  parameter int ADC_ROWS = 4,
  parameter int PIX_BITS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_first,
  input logic                         in_ready,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [PIX_BITS-1:0]          out_pixel,
  input logic [$clog2(ADC_COLS):0]    out_x,
  input logic [$clog2(ADC_ROWS):0]    out_y,
  input logic                         err_flag
);
  // R3: output phase only opens right after a non-first plane was taken
  assert_drain_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && !in_first));

  // R4: each handshake moves strictly forward in raster order
  assert_raster_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || (out_y > $past(out_y)) ||
      ((out_y == $past(out_y)) && (out_x > $past(out_x)))));

  // R5: quarter parity bits do not change within a burst of words
  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |->
      ((out_x[0] == $past(out_x[0])) && (out_y[0] == $past(out_y[0]))));

  // R6: stalled word holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pixel) && $stable(out_x) && $stable(out_y)));

  // R8: error only rises on a taken first-flagged beat
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(in_valid && in_ready && in_first));

  // R9: error is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind bit_plane_assembler bpa_checker #(
  .ADC_COLS (ADC_COLS),
  .ADC_ROWS (ADC_ROWS),
  .PIX_BITS (PIX_BITS)
) u_bpa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_first  (in_first),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pixel (out_pixel),
  .out_x     (out_x),
  .out_y     (out_y),
  .err_flag  (err_flag)
);

// File: tb/bit_plane_assembler_tb.sv
module bit_plane_assembler_tb_top;
  localparam int COLS = 8;
  localparam int ROWS = 4;
  localparam int PB   = 8;
  localparam int N    = COLS * ROWS;
  localparam int XW   = $clog2(COLS) + 1;
  localparam int YW   = $clog2(ROWS) + 1;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_first;
  logic [1:0]    in_quarter;
  logic [N-1:0]  in_bits;
  logic          in_ready;
  logic          out_valid;
  logic          out_ready;
  logic [PB-1:0] out_pixel;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;
  logic          err_flag;

  bit_plane_assembler #(.ADC_COLS(COLS), .ADC_ROWS(ROWS), .PIX_BITS(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_quarter(in_quarter), .in_bits(in_bits), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_x(out_x), .out_y(out_y), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int rdy_mode = 0;
  bit done = 1'b0;

  // ---------------- reference model ----------------
  bit            m_open;
  int            m_cnt;
  logic [1:0]    m_q;
  logic [PB-1:0] m_pix [N];
  bit            m_err;
  int unsigned   exp_q [$];

  always @(posedge clk or negedge rst_n) begin : model
    bit acc;
    int b;
    if (!rst_n) begin
      m_open = 1'b0; m_cnt = 0; m_q = 2'd0; m_err = 1'b0;
      exp_q.delete();
    end else begin
      acc = in_valid && (exp_q.size() == 0);
      if (exp_q.size() != 0 && out_ready) void'(exp_q.pop_front());
      if (acc) begin
        if (in_first) begin
          if (m_open) m_err = 1'b1;
          m_open = 1'b1; m_cnt = 0; m_q = in_quarter;
        end
        if (m_open) begin
          b = PB - 1 - m_cnt;
          for (int i = 0; i < N; i++) m_pix[i][b] = in_bits[i];
          m_cnt++;
          if (m_cnt == PB) begin
            m_open = 1'b0;
            for (int i = 0; i < N; i++) begin
              int unsigned x, y;
              x = 2 * (i % COLS) + m_q[0];
              y = 2 * (i / COLS) + m_q[1];
              exp_q.push_back(m_pix[i] | (x << 8) | (y << 16));
            end
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = (exp_q.size() != 0);
      check(out_valid == ev, "R3/R7 out_valid", int'(out_valid), int'(ev));
      check(in_ready == !ev, "R7 in_ready", int'(in_ready), int'(!ev));
      check(err_flag == m_err, "R8/R9 err_flag", int'(err_flag), int'(m_err));
      if (ev && out_valid) begin
        int unsigned e;
        e = exp_q[0];
        check(out_pixel == e[7:0], "R2/R4/R6/R10/R11 pixel", int'(out_pixel), int'(e[7:0]));
        check(out_x == XW'(e[15:8]), "R4/R5 x", int'(out_x), int'(e[15:8]));
        check(out_y == YW'(e[23:16]), "R4/R5 y", int'(out_y), int'(e[23:16]));
      end
    end
  end

  // consumer back-pressure patterns
  always @(negedge clk) begin
    case (rdy_mode)
      0:       out_ready <= 1'b1;
      1:       out_ready <= (cyc % 3) != 0;
      default: out_ready <= (cyc % 7) == 0;
    endcase
  end

  task automatic report();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      report();
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [PB-1:0] pix_val(input int i, input int seed);
    if (seed == 0) return (i % 2 == 0) ? 8'hFF : 8'h00;
    return PB'(i * 37 + seed * 53 + (i >> 1) * 11);
  endfunction

  // offer junk first-flagged beats while the block is emitting (R7)
  task automatic wait_ready();
    while (exp_q.size() != 0) begin
      in_valid = 1'b1; in_first = 1'b1; in_quarter = 2'd3; in_bits = '1;
      @(negedge clk);
    end
  endtask

  task automatic send_quarter(input logic [1:0] q, input int seed, input int nplanes,
                              input logic [1:0] later_q, input bit gap);
    for (int k = 0; k < nplanes; k++) begin
      @(negedge clk);
      wait_ready();
      in_valid   = 1'b1;
      in_first   = (k == 0);
      in_quarter = (k == 0) ? q : later_q;
      for (int i = 0; i < N; i++) in_bits[i] = pix_val(i, seed)[PB-1-k];
      if (gap) begin
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_bits = '1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_quarter = 2'd0; in_bits = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(err_flag == 1'b0, "R1 err_flag", int'(err_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5: boundary values 0xFF/0x00, quarter 0, consumer always ready
    rdy_mode = 0;
    send_quarter(2'd0, 0, PB, 2'd0, 1'b0);
    // R7: next quarter offered during output; R6 with periodic stalls, gaps between planes
    rdy_mode = 1;
    send_quarter(2'd3, 5, PB, 2'd3, 1'b1);
    drain();

    // R10: stray non-first beat while idle must be ignored
    in_valid = 1'b1; in_first = 1'b0; in_bits = '1;
    @(negedge clk);
    in_valid = 1'b0;
    rdy_mode = 2;
    send_quarter(2'd1, 9, PB, 2'd1, 1'b0);
    drain();

    // R11: later beats carry a different quarter index
    rdy_mode = 1;
    send_quarter(2'd2, 12, PB, 2'd1, 1'b0);
    drain();

    // R8: restart after three planes; R9: flag stays set over a clean quarter
    rdy_mode = 0;
    send_quarter(2'd1, 20, 3, 2'd1, 1'b0);
    send_quarter(2'd2, 33, PB, 2'd2, 1'b0);
    drain();
    send_quarter(2'd0, 40, PB, 2'd0, 1'b1);
    drain();
    repeat (3) @(negedge clk);
    report();
  end
endmodule